// File: doc/BRIEF.md
# Radio Power Mode Controller

This block sequences the power states of a radio transceiver core. Software writes a mode code into a register. The controller turns it into enables for five domains: the core regulator, the reference oscillator, the synthesizer, the receive path and the transmit path. It turns them on in dependency order. Each domain is switched on only after the domain it depends on reports ready. When a domain is no longer needed, it is switched off at once. Inside the block, each domain is modelled as a settle counter with a fixed delay, set by a parameter, between its enable and its ready.

A ready bit tells software when the requested state has been reached. A mode written while a transition is still running is held, and it is applied once that transition completes. Deep sleep removes all power and discards register state. It is left by pulling the active-low select line low. The controller then runs an initialisation in which the serial data-out line is held low until the regulator is up, and it comes back in power-down. A soft reset is a set-then-clear sequence on the reset bit of the mode register. It is only accepted after select has been high for a minimum time, and it returns the registers to their defaults. Two status outputs report regulator readiness and a synchronised brown-out flag.

Mode codes: 0x00 power-down, 0x01 deep sleep, 0x05 standby, 0x08 receive synthesizer on, 0x09 full receive, 0x0B wake-on-radio, 0x0C transmit synthesizer on, 0x0D full transmit.

Top module: `rpm_ctrl`

## Requirements
- R1: Once settled, the enables follow the applied mode: standby turns on the regulator and oscillator. Codes 0x08 and 0x0C add the synthesizer. 0x09 adds the receive path and 0x0D the transmit path. Power-down, deep sleep and wake-on-radio turn every domain off. Receive and transmit paths are never enabled together.
- R2: Domains come up in the order regulator, oscillator, synthesizer, then path. Each enable rises only after the previous domain is ready. From power-down, the ready bit rises after REG_DLY+OSC_DLY+SYN_DLY+PATH_DLY cycles for a full-path mode, and after REG_DLY+OSC_DLY cycles for standby. From standby to 0x09 it takes SYN_DLY+PATH_DLY cycles.
- R3: `rdy` is low from the cycle after a mode write until every domain that the mode needs reports ready and every other domain has dropped. Switching domains off takes one cycle.
- R4: A mode write made while a transition runs is latched, and a later write replaces it. `rd_mode[3:0]` keeps the applied code until the running transition completes. Then the latched code is applied.
- R5: A 7-bit code in `wr_data[6:0]` that is not one of the eight listed codes is applied as power-down and reads back as 0x00.
- R6: `fifo_en` is 1 only in standby, 0x08, 0x09, 0x0C and 0x0D, so FIFO access is blocked and its contents are held cleared otherwise. `lp_tmr_en` is 1 only in wake-on-radio.
- R7: After deep sleep (0x01) is applied and the domains have dropped, all enables, `rdy` and `so_low` are 0, `rd_mode` reads 0x01, and register writes are ignored.
- R8: In deep sleep, `sel_n` low starts initialisation. `so_low` is 1 from the cycle after the edge that samples select low, for exactly REG_DLY samples, until the regulator is ready. The block then runs in power-down, with `rd_mode` at 0x00.
- R9: A write with bit 7 set is taken as a soft-reset arm, and its mode field is ignored. It arms only if `sel_n` has been high for at least SEL_HI_CYC consecutive cycles. While armed, `rd_mode[7]` reads 1. The next write with bit 7 clear resets the mode to power-down and drops any latched write. Its mode field is ignored. A write with bit 7 set that is not armed has no effect.
- R10: `stat_vreg_ok` is 1 while the regulator domain is ready. `stat_bod` follows `vdd_low` through a two-stage synchroniser, two clock edges later.
- R11: After reset, the mode is power-down (`rd_mode` 0x00), all enables and `so_low` are 0, and `rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Write data: [7] soft-reset bit, [6:0] mode code |
| sel_n | input | 1 | Serial select line, active low |
| vdd_low | input | 1 | Brown-out comparator output |
| rd_mode | output | 8 | Readback: [7] reset armed, [3:0] applied mode |
| rdy | output | 1 | Requested mode reached |
| stat_vreg_ok | output | 1 | Regulated supply ready |
| stat_bod | output | 1 | Synchronised brown-out flag |
| en_reg | output | 1 | Core regulator enable |
| en_osc | output | 1 | Reference oscillator enable |
| en_syn | output | 1 | Synthesizer enable |
| en_rx | output | 1 | Receive path enable |
| en_tx | output | 1 | Transmit path enable |
| lp_tmr_en | output | 1 | Low-power wake timer enable |
| fifo_en | output | 1 | FIFO access allowed |
| so_low | output | 1 | Force serial data-out low during wake-up |

## Verification
The ready latency is measured cycle by cycle. The starts are power-down to standby, power-down to full receive, standby to full receive and receive to transmit. These tell the staged chain apart from enables that rise together or a ready bit that ignores a domain. A burst of writes during a transition shows whether writes are held or applied at once, and whether the last one wins. Further runs cover unused codes, wake-on-radio, deep sleep with an ignored write, and the wake-up hold of data-out. Soft-reset runs are made with and without the select-high gap, which separates the qualified reset from a plain mode write.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  localparam int NDOM  = 5;
  localparam int D_REG = 0;
  localparam int D_OSC = 1;
  localparam int D_SYN = 2;
  localparam int D_RX  = 3;
  localparam int D_TX  = 4;

  localparam logic [3:0] M_PD   = 4'h0;
  localparam logic [3:0] M_DSLP = 4'h1;
  localparam logic [3:0] M_STBY = 4'h5;
  localparam logic [3:0] M_SRX  = 4'h8;
  localparam logic [3:0] M_FRX  = 4'h9;
  localparam logic [3:0] M_WOR  = 4'hB;
  localparam logic [3:0] M_STX  = 4'hC;
  localparam logic [3:0] M_FTX  = 4'hD;

  typedef enum logic [1:0] {ST_RUN, ST_DSLP, ST_INIT} pstate_t;

  // Map a written 7-bit code onto an applied code; unknown codes become power-down.
  function automatic logic [3:0] norm_code(input logic [6:0] c);
    case (c)
      7'h00, 7'h01, 7'h05, 7'h08, 7'h09, 7'h0B, 7'h0C, 7'h0D: norm_code = c[3:0];
      default: norm_code = M_PD;
    endcase
  endfunction

  // Domains required by an applied mode, bit index per D_* above.
  function automatic logic [NDOM-1:0] need_of(input logic [3:0] m);
    case (m)
      M_STBY:       need_of = 5'b00011;
      M_SRX, M_STX: need_of = 5'b00111;
      M_FRX:        need_of = 5'b01111;
      M_FTX:        need_of = 5'b10111;
      default:      need_of = 5'b00000;
    endcase
  endfunction

  function automatic logic fifo_of(input logic [3:0] m);
    fifo_of = (m == M_STBY) || (m == M_SRX) || (m == M_FRX) ||
              (m == M_STX) || (m == M_FTX);
  endfunction
endpackage

// File: rtl/rpm_domain.sv
// Settle model for one power domain: ready after DLY enabled cycles.
module rpm_domain #(
  parameter int DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic rdy
);
  localparam int W = $clog2(DLY + 1);
  localparam logic [W-1:0] LAST = W'(DLY);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en)               cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rdy = (cnt_q == LAST);
endmodule

// File: rtl/rpm_sel_gap.sv
// Flags that the select line has been high for N consecutive cycles.
module rpm_sel_gap #(
  parameter int N = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  output logic gap_ok
);
  localparam int W = $clog2(N + 1);
  localparam logic [W-1:0] SAT = W'(N);

  logic [W-1:0] hi_q, hi_d;

  always_comb begin
    if (!sel_n)          hi_d = '0;
    else if (hi_q != SAT) hi_d = hi_q + 1'b1;
    else                 hi_d = hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  assign gap_ok = (hi_q == SAT);
endmodule

// File: rtl/rpm_ctrl.sv
module rpm_ctrl
  import rpm_pkg::*;
#(
  parameter int REG_DLY    = 64,
  parameter int OSC_DLY    = 62500,
  parameter int SYN_DLY    = 5000,
  parameter int PATH_DLY   = 32,
  parameter int SEL_HI_CYC = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       sel_n,
  input  logic       vdd_low,
  output logic [7:0] rd_mode,
  output logic       rdy,
  output logic       stat_vreg_ok,
  output logic       stat_bod,
  output logic       en_reg,
  output logic       en_osc,
  output logic       en_syn,
  output logic       en_rx,
  output logic       en_tx,
  output logic       lp_tmr_en,
  output logic       fifo_en,
  output logic       so_low
);
  localparam logic [NDOM-1:0] NEED_REG = NDOM'(1) << D_REG;

  pstate_t         st_q, st_d;
  logic [3:0]      cur_q, cur_d, pend_q, pend_d;
  logic            pv_q, pv_d, arm_q, arm_d;
  logic [1:0]      bod_q;
  logic [NDOM-1:0] need, en, dom_rdy;
  logic            gap_ok, settled, run, wr_set, wr_clr;

  // Domains required now: init needs only the regulator, sleep needs none.
  always_comb begin
    case (st_q)
      ST_INIT: need = NEED_REG;
      ST_DSLP: need = '0;
      default: need = need_of(cur_q);
    endcase
  end

  // Dependency chain: each enable waits for the ready of the domain below it.
  always_comb begin
    en[D_REG] = need[D_REG];
    en[D_OSC] = need[D_OSC] & dom_rdy[D_REG];
    en[D_SYN] = need[D_SYN] & dom_rdy[D_OSC];
    en[D_RX]  = need[D_RX]  & dom_rdy[D_SYN];
    en[D_TX]  = need[D_TX]  & dom_rdy[D_SYN];
  end

  for (genvar gi = 0; gi < NDOM; gi++) begin : g_dom
    localparam int DLY = (gi == D_REG) ? REG_DLY :
                         (gi == D_OSC) ? OSC_DLY :
                         (gi == D_SYN) ? SYN_DLY : PATH_DLY;
    rpm_domain #(.DLY(DLY)) u_dom (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en[gi]),
      .rdy  (dom_rdy[gi])
    );
  end

  rpm_sel_gap #(.N(SEL_HI_CYC)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_n (sel_n),
    .gap_ok(gap_ok)
  );

  assign settled = (dom_rdy == need);
  assign run     = (st_q == ST_RUN);
  assign wr_set  = run & wr_en & wr_data[7];
  assign wr_clr  = run & wr_en & ~wr_data[7];

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    pend_d = pend_q;
    pv_d   = pv_q;
    arm_d  = arm_q;
    case (st_q)
      ST_RUN: begin
        if (wr_clr && arm_q) begin
          cur_d = M_PD;
          pv_d  = 1'b0;
          arm_d = 1'b0;
        end else begin
          if (wr_set && gap_ok) arm_d = 1'b1;
          if (wr_clr) begin
            if (settled && !pv_q) begin
              cur_d = norm_code(wr_data[6:0]);
            end else begin
              pv_d   = 1'b1;
              pend_d = norm_code(wr_data[6:0]);
            end
          end else if (settled && pv_q) begin
            cur_d = pend_q;
            pv_d  = 1'b0;
          end else if (settled && cur_q == M_DSLP) begin
            st_d = ST_DSLP;
          end
        end
      end
      ST_DSLP: begin
        if (!sel_n) begin
          st_d  = ST_INIT;
          cur_d = M_PD;
          pv_d  = 1'b0;
          arm_d = 1'b0;
        end
      end
      default: begin
        if (dom_rdy[D_REG]) st_d = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      cur_q  <= M_PD;
      pend_q <= M_PD;
      pv_q   <= 1'b0;
      arm_q  <= 1'b0;
      bod_q  <= 2'b00;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
      arm_q  <= arm_d;
      bod_q  <= {bod_q[0], vdd_low};
    end
  end

  assign rd_mode      = {arm_q, 3'b000, cur_q};
  assign rdy          = run & settled & ~pv_q & (cur_q != M_DSLP);
  assign stat_vreg_ok = dom_rdy[D_REG];
  assign stat_bod     = bod_q[1];
  assign en_reg       = en[D_REG];
  assign en_osc       = en[D_OSC];
  assign en_syn       = en[D_SYN];
  assign en_rx        = en[D_RX];
  assign en_tx        = en[D_TX];
  assign lp_tmr_en    = run & (cur_q == M_WOR);
  assign fifo_en      = run & fifo_of(cur_q);
  assign so_low       = (st_q == ST_INIT) & ~dom_rdy[D_REG];
endmodule

// File: rtl/rpm_ctrl_chk.sv
module rpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode,
  input logic       rdy,
  input logic       stat_vreg_ok,
  input logic       en_reg,
  input logic       en_osc,
  input logic       en_syn,
  input logic       en_rx,
  input logic       en_tx,
  input logic       lp_tmr_en,
  input logic       fifo_en,
  input logic       so_low
);
  a_r2_osc_after_reg: assert property (@(posedge clk) disable iff (!rst_n)
    en_osc |-> stat_vreg_ok && en_reg);
  a_r2_syn_after_osc: assert property (@(posedge clk) disable iff (!rst_n)
    en_syn |-> en_osc);
  a_r2_path_after_syn: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rx || en_tx) |-> en_syn);
  a_r1_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_rx && en_tx));
  a_r3_rx_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && mode == 4'h9) |-> (en_rx && en_syn && !en_tx));
  a_r6_wor_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lp_tmr_en |-> (!en_reg && !fifo_en));
  a_r8_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
    so_low |-> (!rdy && !fifo_en && en_reg));
endmodule

bind rpm_ctrl rpm_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (rd_mode[3:0]),
  .rdy         (rdy),
  .stat_vreg_ok(stat_vreg_ok),
  .en_reg      (en_reg),
  .en_osc      (en_osc),
  .en_syn      (en_syn),
  .en_rx       (en_rx),
  .en_tx       (en_tx),
  .lp_tmr_en   (lp_tmr_en),
  .fifo_en     (fifo_en),
  .so_low      (so_low)
);

// File: tb/sim_rpm_ctrl.sv
module sim_rpm_ctrl;
  localparam int RD = 3, OD = 10, SD = 5, PD = 2, GAP = 13;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, sel_n, vdd_low;
  logic [7:0] wr_data, rd_mode;
  logic       rdy, stat_vreg_ok, stat_bod, en_reg, en_osc, en_syn, en_rx, en_tx;
  logic       lp_tmr_en, fifo_en, so_low;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  rpm_ctrl #(.REG_DLY(RD), .OSC_DLY(OD), .SYN_DLY(SD), .PATH_DLY(PD),
             .SEL_HI_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .sel_n(sel_n),
    .vdd_low(vdd_low), .rd_mode(rd_mode), .rdy(rdy), .stat_vreg_ok(stat_vreg_ok),
    .stat_bod(stat_bod), .en_reg(en_reg), .en_osc(en_osc), .en_syn(en_syn),
    .en_rx(en_rx), .en_tx(en_tx), .lp_tmr_en(lp_tmr_en), .fifo_en(fifo_en),
    .so_low(so_low));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Drives a write at a negedge; returns at the sample just after the write edge.
  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rdy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  function automatic int en_vec();
    return {27'd0, en_tx, en_rx, en_syn, en_osc, en_reg};
  endfunction

  task automatic t_reset();
    chk("R11 mode after reset", rd_mode, 8'h00);
    chk("R11 enables after reset", en_vec(), 0);
    chk("R11 rdy after reset", rdy, 1);
    chk("R11 so_low after reset", so_low, 0);
    chk("R6 fifo blocked in power-down", fifo_en, 0);
  endtask

  task automatic t_standby();
    int n;
    wr(8'h05); wait_rdy(n);
    chk("R2 pd->stby latency", n, RD + OD);
    chk("R1 stby enables", en_vec(), 5'b00011);
    chk("R6 fifo open in stby", fifo_en, 1);
    chk("R10 vreg_ok in stby", stat_vreg_ok, 1);
  endtask

  task automatic t_rx_tx();
    int n;
    wr(8'h09); wait_rdy(n);
    chk("R2 stby->rx latency", n, SD + PD);
    chk("R1 full rx enables", en_vec(), 5'b01111);
    wr(8'h0D); wait_rdy(n);
    chk("R3 rx->tx latency", n, PD);
    chk("R1 full tx enables", en_vec(), 5'b10111);
    wr(8'h00); wait_rdy(n);
    chk("R3 shutdown latency", n, 1);
    chk("R1 pd enables", en_vec(), 0);
    chk("R10 vreg_ok off in pd", stat_vreg_ok, 0);
    wr(8'h09); wait_rdy(n);
    chk("R2 pd->rx latency", n, RD + OD + SD + PD);
    wr(8'h00); wait_rdy(n);
  endtask

  task automatic t_pending();
    int n;
    wr(8'h09);
    wr(8'h0D);
    wr(8'h05);
    chk("R4 applied mode held while busy", rd_mode, 8'h09);
    chk("R3 rdy low while busy", rdy, 0);
    wait_rdy(n);
    chk("R4 last latched write applied", rd_mode, 8'h05);
    chk("R4 enables after latched stby", en_vec(), 5'b00011);
  endtask

  task automatic t_unused();
    int n;
    wr(8'h03); wait_rdy(n);
    chk("R5 code 0x03 reads power-down", rd_mode, 8'h00);
    chk("R5 code 0x03 enables off", en_vec(), 0);
    wr(8'h05); wait_rdy(n);
    wr(8'h15); wait_rdy(n);
    chk("R5 code 0x15 reads power-down", rd_mode, 8'h00);
    chk("R5 code 0x15 fifo blocked", fifo_en, 0);
  endtask

  task automatic t_wor();
    int n;
    wr(8'h0B); wait_rdy(n);
    chk("R6 wor timer on", lp_tmr_en, 1);
    chk("R6 wor fifo blocked", fifo_en, 0);
    chk("R1 wor enables off", en_vec(), 0);
    wr(8'h05); wait_rdy(n);
    chk("R6 timer off in stby", lp_tmr_en, 0);
  endtask

  task automatic t_deep_sleep();
    int n;
    wr(8'h01); idle(5);
    chk("R7 sleep enables off", en_vec(), 0);
    chk("R7 sleep rdy low", rdy, 0);
    wr(8'h05); idle(20);
    chk("R7 write ignored in sleep (mode)", rd_mode, 8'h01);
    chk("R7 write ignored in sleep (enable)", en_reg, 0);
    chk("R7 so_low idle in sleep", so_low, 0);
    @(negedge clk); sel_n = 1'b0;
    @(negedge clk);
    n = 0;
    while (so_low && n < 100) begin n++; @(negedge clk); end
    chk("R8 data-out hold length", n, RD);
    sel_n = 1'b1;
    idle(4);
    chk("R8 wake defaults to power-down", rd_mode, 8'h00);
    chk("R8 ready after wake", rdy, 1);
  endtask

  task automatic t_srst_ok();
    int n;
    wr(8'h05); wait_rdy(n);
    idle(GAP + 5);
    wr(8'h85);
    chk("R9 armed readback", rd_mode, 8'h85);
    wr(8'h05); wait_rdy(n);
    chk("R9 soft reset to power-down", rd_mode, 8'h00);
    chk("R9 soft reset enables off", en_vec(), 0);
  endtask

  task automatic t_srst_short();
    int n;
    wr(8'h05); wait_rdy(n);
    @(negedge clk); sel_n = 1'b0;
    @(negedge clk); sel_n = 1'b1;
    idle(4);
    wr(8'h85);
    chk("R9 no arm without gap", rd_mode, 8'h05);
    wr(8'h05); wait_rdy(n);
    chk("R9 no reset without gap", rd_mode, 8'h05);
    chk("R9 stby kept", en_osc, 1);
  endtask

  task automatic t_bod();
    @(negedge clk); vdd_low = 1'b1;
    @(negedge clk);
    chk("R10 bod after one edge", stat_bod, 0);
    @(negedge clk);
    chk("R10 bod after two edges", stat_bod, 1);
    vdd_low = 1'b0;
    @(negedge clk);
    chk("R10 bod release after one edge", stat_bod, 1);
    @(negedge clk);
    chk("R10 bod release after two edges", stat_bod, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; sel_n = 1'b1; vdd_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_standby();
    t_rx_tx();
    t_pending();
    t_unused();
    t_wor();
    t_deep_sleep();
    t_srst_ok();
    t_srst_short();
    t_bod();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule